// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial-clock timing for an I2C master. A prescaler divides the system clock down to a slower module clock. Two phase counters then run on that module clock: the first times the low half of SCL and the second times the high half. Each half is stretched by a small fixed number of extra module cycles. That number depends on the prescaler setting: 7 when the prescaler is 0, 6 when it is 1, and 5 when it is 2 or larger.

The divider settings are captured only while the run enable is low. While the block runs, it ignores any change on those inputs. When the block is enabled, it always starts with the low phase. It raises a one-cycle phase tick on the last system cycle of each half, so that a bit sequencer can advance. When the block is disabled, it clears every counter and releases SCL.

Top module: `scl_clk_div`

## Requirements
- R1: After reset, and on the first system cycle after run_i has been sampled low, scl_low_o, phase_high_o, mod_tick_o and edge_tick_o are all 0.
- R2: While running, mod_tick_o pulses for one system cycle every (psc+1) cycles. The first pulse comes on the (psc+1)th cycle after the edge that samples run_i high.
- R3: The extra count d added to each phase is 7 for psc=0, 6 for psc=1 and 5 for psc>=2.
- R4: After enable, the low phase comes first. scl_low_o stays 1 for exactly (low+d)*(psc+1) system cycles, which spans low+d module ticks.
- R5: The high phase follows the low phase. phase_high_o stays 1 for (high+d)*(psc+1) cycles, then the low phase starts again.
- R6: edge_tick_o is high for one cycle at the end of each phase, together with a mod_tick_o pulse. It pulses exactly once per phase.
- R7: psc_i, low_cnt_i and high_cnt_i are loaded only while run_i is 0. Changes made while running do not alter the phase lengths.
- R8: Taking run_i low clears the counters. A later enable starts a full-length low phase.
- R9: psc, low and high are 16-bit fields. scl_low_o and phase_high_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; settings are loaded while this is 0 |
| psc_i | input | 16 | Prescaler value; the module clock is the system clock divided by psc+1 |
| low_cnt_i | input | 16 | Low-phase count, before the extra d cycles are added |
| high_cnt_i | input | 16 | High-phase count, before the extra d cycles are added |
| mod_tick_o | output | 1 | One-cycle module-clock tick |
| scl_low_o | output | 1 | Request to drive SCL low |
| phase_high_o | output | 1 | 1 during the high phase while running |
| edge_tick_o | output | 1 | One-cycle pulse on the last cycle of each phase |

## Verification
A vector table covers psc values 0, 1, 2 and 5, together with zero and non-zero low and high counts. Each row measures the low length, the high length, the number of module ticks and the number of phase ticks. These rows tell the three d values apart, and they also tell prescaler scaling apart from phase-count scaling. Directed tests then check the following:
- the position of the first module tick;
- that inputs changed during a run are ignored;
- that a run interrupted mid-phase restarts with a full low phase.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  // extra module cycles added to each SCL phase
  function automatic logic [2:0] phase_pad(input logic psc_is_0, input logic psc_is_1);
    if (psc_is_0)      return 3'd7;
    else if (psc_is_1) return 3'd6;
    else               return 3'd5;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_div_pkg::*;
#(
  parameter int W = 16,
  localparam int LW = W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] low_i,
  input  logic [W-1:0] high_i,
  input  logic [2:0]   pad_i,
  output scl_phase_e   phase_o,
  output logic         edge_o
);
  logic [LW-1:0] cnt_q, limit;
  scl_phase_e    phase_q;

  assign limit   = ((phase_q == PH_LOW) ? {1'b0, low_i} : {1'b0, high_i})
                 + LW'(pad_i);
  assign edge_o  = en_i && tick_i && (cnt_q == limit - 1'b1);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else if (edge_o) begin
      cnt_q   <= '0;
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
  import scl_div_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             mod_tick_o,
  output logic             scl_low_o,
  output logic             phase_high_o,
  output logic             edge_tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] low_q, high_q;
  logic [2:0]       pad_q;
  logic             active_q;
  scl_phase_e       phase;

  // settings are shadowed only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      psc_q    <= '0;
      low_q    <= '0;
      high_q   <= '0;
      pad_q    <= 3'd7;
    end else if (!run_i) begin
      active_q <= 1'b0;
      psc_q    <= psc_i;
      low_q    <= low_cnt_i;
      high_q   <= high_cnt_i;
      pad_q    <= phase_pad(psc_i == '0, psc_i == PSC_W'(1));
    end else begin
      active_q <= 1'b1;
    end
  end

  scl_prescaler #(.W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active_q),
    .div_i  (psc_q),
    .tick_o (mod_tick_o)
  );

  scl_phase_ctr #(.W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (active_q),
    .tick_i  (mod_tick_o),
    .low_i   (low_q),
    .high_i  (high_q),
    .pad_i   (pad_q),
    .phase_o (phase),
    .edge_o  (edge_tick_o)
  );

  assign scl_low_o    = active_q && (phase == PH_LOW);
  assign phase_high_o = active_q && (phase == PH_HIGH);
endmodule

// File: rtl/scl_clk_div_chk.sv
module scl_clk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic mod_tick_o,
  input logic scl_low_o,
  input logic phase_high_o,
  input logic edge_tick_o
);
  // R6
  edge_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_tick_o |-> mod_tick_o);

  // R1 R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!scl_low_o && !phase_high_o && !mod_tick_o && !edge_tick_o));

  // R4
  low_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_low_o) && run_i && $past(run_i)) |-> $past(edge_tick_o));

  // R5
  high_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_high_o) |-> $past(edge_tick_o));

  // R9
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_o && phase_high_o));
endmodule

bind scl_clk_div scl_clk_div_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .mod_tick_o   (mod_tick_o),
  .scl_low_o    (scl_low_o),
  .phase_high_o (phase_high_o),
  .edge_tick_o  (edge_tick_o)
);

// File: tb/sim_scl_clk_div.sv
`timescale 1ns/1ps
module sim_scl_clk_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] psc_i = '0, low_cnt_i = '0, high_cnt_i = '0;
  logic        mod_tick_o, scl_low_o, phase_high_o, edge_tick_o;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk_i = ~clk_i;

  scl_clk_div u0 (.*);

  typedef struct packed {
    logic [15:0] psc, lo, hi, exp_lo, exp_hi;
  } vec_t;

  // exp = (cnt + d) * (psc + 1), d from R3
  localparam vec_t VECS [5] = '{
    '{16'd0, 16'd1,  16'd2, 16'd8,  16'd9},
    '{16'd1, 16'd0,  16'd0, 16'd12, 16'd12},
    '{16'd2, 16'd3,  16'd1, 16'd24, 16'd18},
    '{16'd5, 16'd2,  16'd4, 16'd42, 16'd54},
    '{16'd0, 16'd10, 16'd3, 16'd17, 16'd10}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    @(negedge clk_i);
    run_i = 1'b0; psc_i = v.psc; low_cnt_i = v.lo; high_cnt_i = v.hi;
    @(negedge clk_i);
    run_i = 1'b1;
    @(negedge clk_i);
  endtask

  // count negedge samples while scl_low_o == want_low
  task automatic count_level(input logic want_low, output int n,
                             output int ticks, output int edges);
    n = 0; ticks = 0; edges = 0;
    while (scl_low_o == want_low && n < 4000) begin
      n++;
      ticks += int'(mod_tick_o);
      edges += int'(edge_tick_o);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, t, e;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 scl_low", int'(scl_low_o), 0);
    chk("R1 phase_high", int'(phase_high_o), 0);
    chk("R1 mod_tick", int'(mod_tick_o), 0);
    chk("R1 edge_tick", int'(edge_tick_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle scl_low", int'(scl_low_o), 0);

    foreach (VECS[i]) begin
      load(VECS[i]);
      count_level(1'b1, n, t, e);
      chk($sformatf("R4 low len v%0d", i), n, int'(VECS[i].exp_lo));
      chk($sformatf("R3 low ticks v%0d", i), t,
          int'(VECS[i].exp_lo) / (int'(VECS[i].psc) + 1));
      chk($sformatf("R6 low edges v%0d", i), e, 1);
      chk($sformatf("R5 phase_high v%0d", i), int'(phase_high_o), 1);
      count_level(1'b0, n, t, e);
      chk($sformatf("R5 high len v%0d", i), n, int'(VECS[i].exp_hi));
      chk($sformatf("R6 high edges v%0d", i), e, 1);
      chk($sformatf("R5 relow v%0d", i), int'(scl_low_o), 1);
    end

    // R2 first module tick at the (psc+1)th cycle
    load('{16'd3, 16'd1, 16'd1, 16'd0, 16'd0});
    n = 1;
    while (!mod_tick_o && n < 100) begin n++; @(negedge clk_i); end
    chk("R2 first tick", n, 4);
    @(negedge clk_i);
    n = 1;
    while (!mod_tick_o && n < 100) begin n++; @(negedge clk_i); end
    chk("R2 tick spacing", n, 4);

    // R7 inputs changed while running are ignored
    load(VECS[0]);
    count_level(1'b1, n, t, e);
    psc_i = 16'd7; low_cnt_i = 16'd30; high_cnt_i = 16'd30;
    count_level(1'b0, n, t, e);
    chk("R7 high unchanged", n, 9);
    count_level(1'b1, n, t, e);
    chk("R7 low unchanged", n, 8);

    // R8 disable mid-phase, then re-enable
    load(VECS[2]);
    repeat (5) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    chk("R8 released", int'(scl_low_o), 0);
    chk("R8 no tick", int'(mod_tick_o), 0);
    run_i = 1'b1;
    @(negedge clk_i);
    count_level(1'b1, n, t, e);
    chk("R8 full low", n, 24);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule